// File: doc/BRIEF.md
# DTMF Digit Steering and Output Latch

This block sits behind a dual-tone pair detector and turns its raw per-sample decisions into clean keypad digits. Each clock it receives a flag saying a valid row/column tone pair is present, plus the row index and the column index of that pair. It times how long a pair lasts and how long the silence after it lasts, using cycle counts set by parameters. A digit is accepted only when both timings are long enough. Accepted digits go into a 4-bit output latch.

Three outputs report progress. `early_steer` follows the raw detection one cycle late. `delayed_steer` rises in the same cycle the latch takes a new digit and falls once a full pause has been seen. Short dropouts inside a tone are bridged, so one key press gives one digit.

Three side inputs change the behaviour. `col4_inhibit` masks the fourth-column keys. `power_down` halts detection. `out_en` gates the data outputs.

Top module: `dtmf_digit_steer`

## Requirements
- R1: A pair is encoded as index = row*4 + col. Row indices 0..3 are the rows from low to high frequency and column indices 0..3 are the columns from low to high. Key 1..9 gives code 1..9, key 0 gives 10, * gives 11, # gives 12, A/B/C/D (column 3, rows 0..3) give 13/14/15/0.
- R2: `early_steer` is high in the cycle after an edge that sampled a qualified pair, and low in the cycle after any edge that sampled no qualified pair.
- R3: After TONE_CYC consecutive edges that sample the same qualified pair, from an armed state, the latch holds that pair's code. `delayed_steer` is high right after the TONE_CYC-th edge.
- R4: A run of fewer than TONE_CYC samples leaves `delayed_steer` low and the latch unchanged.
- R5: If the pair changes while it is being qualified, qualification restarts, and the new pair needs TONE_CYC samples of its own.
- R6: Once a digit is latched, a dropout of fewer than PAUSE_CYC samples keeps `delayed_steer` high. No new digit is taken during the dropout or after it, even if the returning pair is different.
- R7: PAUSE_CYC consecutive samples without a qualified pair drop `delayed_steer` right after the PAUSE_CYC-th edge and arm the block for the next digit.
- R8: While `col4_inhibit` is high, a pair with column index 3 is treated as absent. It produces neither early steering nor a latch update.
- R9: With `out_en` low, `digit_out` is 0. With `out_en` high, `digit_out` shows the last latched code, which is kept through pauses.
- R10: While `power_down` is high, both steering outputs are low in the following cycle and any tone qualification in progress is abandoned. The latched code is kept.
- R11: After reset both steering outputs are low and the latch holds 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one detector sample per cycle |
| rst | input | 1 | Synchronous active-high reset |
| pair_valid | input | 1 | Detector reports a valid tone pair this sample |
| row_idx | input | 2 | Row frequency index, 0 = lowest |
| col_idx | input | 2 | Column frequency index, 0 = lowest |
| col4_inhibit | input | 1 | Mask the column-3 keys |
| power_down | input | 1 | Halt detection and drop steering |
| out_en | input | 1 | Enable the data outputs |
| early_steer | output | 1 | Raw detection, registered |
| delayed_steer | output | 1 | Digit latched and pause not yet validated |
| digit_out | output | 4 | Latched digit code, 0 when disabled |

## Verification
The bench builds the block with TONE_CYC = 6 and PAUSE_CYC = 4. These small values let every timing edge be hit exactly: one sample short of the tone time and the exact tone time, one sample short of the pause and the exact pause. All 16 keys are walked in a few hundred cycles. With these values the bench also checks dropout bridging, a pair change during qualification, power-down in mid-qualification and in mid-hold, and inhibit of a column-3 key against a key in another column.

// File: rtl/dtmf_steer_pkg.sv
package dtmf_steer_pkg;

    typedef struct packed {
        logic [1:0] row;
        logic [1:0] col;
    } tone_pair_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_QUAL,
        ST_HELD,
        ST_GAP
    } steer_state_e;

    localparam logic [1:0] LAST_COL = 2'd3;
    localparam logic [1:0] LAST_ROW = 2'd3;

    // Key code: digits map to themselves, 0 -> 10, * -> 11, # -> 12,
    // column-3 keys -> 13,14,15 and finally 0 on the bottom row.
    function automatic logic [3:0] code_of(input tone_pair_t p);
        logic [3:0] c;
        if (p.col == LAST_COL) begin
            c = (p.row == LAST_ROW) ? 4'd0 : 4'd13 + {2'b00, p.row};
        end else if (p.row != LAST_ROW) begin
            c = 4'd1 + {2'b00, p.col} + 4'd3 * {2'b00, p.row};
        end else begin
            case (p.col)
                2'd0:    c = 4'd11;
                2'd1:    c = 4'd10;
                default: c = 4'd12;
            endcase
        end
        return c;
    endfunction

endpackage

// File: rtl/dtmf_input_qual.sv
module dtmf_input_qual
    import dtmf_steer_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       pair_valid_i,
    input  logic [1:0] row_i,
    input  logic [1:0] col_i,
    input  logic       inhibit_i,
    input  logic       pd_i,
    output logic       q_valid_o,
    output tone_pair_t pair_o,
    output logic [3:0] code_o,
    output logic       early_o
);
    logic masked;
    logic early_q;

    assign pair_o    = '{row: row_i, col: col_i};
    assign masked    = inhibit_i && (col_i == LAST_COL);
    assign q_valid_o = pair_valid_i && !masked && !pd_i;
    assign code_o    = code_of(pair_o);

    always_ff @(posedge clk) begin
        if (rst) early_q <= 1'b0;
        else     early_q <= q_valid_o;
    end
    assign early_o = early_q;

    // R2: a missing pair clears early steering on the next cycle
    a_r2_early_drops: assert property (@(posedge clk) disable iff (rst)
        !pair_valid_i |=> !early_o);

    // R8: an inhibited column-3 key never shows on early steering
    a_r8_inhibit_masks: assert property (@(posedge clk) disable iff (rst)
        (inhibit_i && col_i == LAST_COL) |=> !early_o);

endmodule

// File: rtl/dtmf_steer_fsm.sv
module dtmf_steer_fsm
    import dtmf_steer_pkg::*;
#(
    parameter int TONE_CYC  = 6,
    parameter int PAUSE_CYC = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pd_i,
    input  logic       q_valid_i,
    input  tone_pair_t pair_i,
    output logic       load_o,
    output logic       dstv_o
);
    localparam int CNT_MAX = (TONE_CYC > PAUSE_CYC) ? TONE_CYC : PAUSE_CYC;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] TONE_LAST  = CNT_W'(TONE_CYC - 1);
    localparam logic [CNT_W-1:0] PAUSE_LAST = CNT_W'(PAUSE_CYC - 1);
    localparam logic [CNT_W-1:0] CNT_ONE    = CNT_W'(1);

    steer_state_e     state_q;
    logic [CNT_W-1:0] cnt_q;
    tone_pair_t       cand_q;
    logic             dstv_q;

    assign load_o = !pd_i && (state_q == ST_QUAL) && q_valid_i
                    && (pair_i == cand_q) && (cnt_q == TONE_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            cand_q  <= '0;
            dstv_q  <= 1'b0;
        end else if (pd_i) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            dstv_q  <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (q_valid_i) begin
                        state_q <= ST_QUAL;
                        cand_q  <= pair_i;
                        cnt_q   <= CNT_ONE;
                    end
                end
                ST_QUAL: begin
                    if (!q_valid_i) begin
                        state_q <= ST_IDLE;
                        cnt_q   <= '0;
                    end else if (pair_i != cand_q) begin
                        cand_q <= pair_i;
                        cnt_q  <= CNT_ONE;
                    end else if (cnt_q == TONE_LAST) begin
                        state_q <= ST_HELD;
                        cnt_q   <= '0;
                        dstv_q  <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q + CNT_ONE;
                    end
                end
                ST_HELD: begin
                    if (!q_valid_i) begin
                        state_q <= ST_GAP;
                        cnt_q   <= CNT_ONE;
                    end
                end
                default: begin
                    if (q_valid_i) begin
                        state_q <= ST_HELD;
                        cnt_q   <= '0;
                    end else if (cnt_q == PAUSE_LAST) begin
                        state_q <= ST_IDLE;
                        cnt_q   <= '0;
                        dstv_q  <= 1'b0;
                    end else begin
                        cnt_q <= cnt_q + CNT_ONE;
                    end
                end
            endcase
        end
    end
    assign dstv_o = dstv_q;

    // R3: delayed steering rises only on a sampled qualified pair
    a_r3_rise_on_tone: assert property (@(posedge clk) disable iff (rst)
        $rose(dstv_q) |-> $past(q_valid_i));

    // R7: delayed steering falls only after an absent sample or power-down
    a_r7_fall_on_gap: assert property (@(posedge clk) disable iff (rst)
        $fell(dstv_q) |-> ($past(!q_valid_i) || $past(pd_i)));

    // R5: the timing counter stays within its longest window
    a_r5_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_W'(CNT_MAX));

endmodule

// File: rtl/dtmf_out_latch.sv
module dtmf_out_latch (
    input  logic       clk,
    input  logic       rst,
    input  logic       load_i,
    input  logic [3:0] code_i,
    input  logic       oe_i,
    output logic [3:0] digit_o
);
    logic [3:0] code_q;

    always_ff @(posedge clk) begin
        if (rst)         code_q <= 4'd0;
        else if (load_i) code_q <= code_i;
    end

    assign digit_o = oe_i ? code_q : 4'd0;

    // R4: the stored digit moves only on a load strobe
    a_r4_hold_without_load: assert property (@(posedge clk) disable iff (rst)
        !load_i |=> $stable(code_q));

endmodule

// File: rtl/dtmf_digit_steer.sv
module dtmf_digit_steer
    import dtmf_steer_pkg::*;
#(
    parameter int TONE_CYC  = 6,
    parameter int PAUSE_CYC = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pair_valid,
    input  logic [1:0] row_idx,
    input  logic [1:0] col_idx,
    input  logic       col4_inhibit,
    input  logic       power_down,
    input  logic       out_en,
    output logic       early_steer,
    output logic       delayed_steer,
    output logic [3:0] digit_out
);
    logic       q_valid;
    tone_pair_t pair;
    logic [3:0] code;
    logic       load;

    dtmf_input_qual u_qual (
        .clk          (clk),
        .rst          (rst),
        .pair_valid_i (pair_valid),
        .row_i        (row_idx),
        .col_i        (col_idx),
        .inhibit_i    (col4_inhibit),
        .pd_i         (power_down),
        .q_valid_o    (q_valid),
        .pair_o       (pair),
        .code_o       (code),
        .early_o      (early_steer)
    );

    dtmf_steer_fsm #(
        .TONE_CYC  (TONE_CYC),
        .PAUSE_CYC (PAUSE_CYC)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .pd_i      (power_down),
        .q_valid_i (q_valid),
        .pair_i    (pair),
        .load_o    (load),
        .dstv_o    (delayed_steer)
    );

    dtmf_out_latch u_latch (
        .clk     (clk),
        .rst     (rst),
        .load_i  (load),
        .code_i  (code),
        .oe_i    (out_en),
        .digit_o (digit_out)
    );

    // R10: power-down silences both steering outputs next cycle
    a_r10_pd_quiet: assert property (@(posedge clk) disable iff (rst)
        power_down |=> (!early_steer && !delayed_steer));

    // R3: a latch load always comes with delayed steering in the next cycle
    a_r3_load_raises_dstv: assert property (@(posedge clk) disable iff (rst)
        load |=> delayed_steer);

endmodule

// File: tb/test_dtmf_digit_steer.sv
module test_dtmf_digit_steer;
    localparam int T = 6;
    localparam int P = 4;

    // {row[1:0], col[1:0], code[3:0]} for all 16 keys
    localparam logic [7:0] VEC [16] = '{
        8'h01, 8'h12, 8'h23, 8'h3D,
        8'h44, 8'h55, 8'h66, 8'h7E,
        8'h87, 8'h98, 8'hA9, 8'hBF,
        8'hCB, 8'hDA, 8'hEC, 8'hF0
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pair_valid = 1'b0;
    logic [1:0] row_idx = 2'd0;
    logic [1:0] col_idx = 2'd0;
    logic       col4_inhibit = 1'b0;
    logic       power_down = 1'b0;
    logic       out_en = 1'b1;
    logic       early_steer;
    logic       delayed_steer;
    logic [3:0] digit_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    dtmf_digit_steer #(.TONE_CYC(T), .PAUSE_CYC(P)) i_dtmf_digit_steer (
        .clk           (clk),
        .rst           (rst),
        .pair_valid    (pair_valid),
        .row_idx       (row_idx),
        .col_idx       (col_idx),
        .col4_inhibit  (col4_inhibit),
        .power_down    (power_down),
        .out_en        (out_en),
        .early_steer   (early_steer),
        .delayed_steer (delayed_steer),
        .digit_out     (digit_out)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic hold(input logic v, input logic [1:0] r, input logic [1:0] c, input int n);
        pair_valid = v;
        row_idx    = r;
        col_idx    = c;
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        chk("R11 dstv", int'(delayed_steer), 0);
        chk("R11 early", int'(early_steer), 0);
        chk("R11 digit", int'(digit_out), 0);
        rst = 1'b0;
        @(negedge clk);

        // R1 / R3 / R7: every key through the table
        for (int i = 0; i < 16; i++) begin
            hold(1'b1, VEC[i][7:6], VEC[i][5:4], T);
            chk("R3 dstv after tone", int'(delayed_steer), 1);
            chk("R1 code", int'(digit_out), int'(VEC[i][3:0]));
            hold(1'b0, 2'd0, 2'd0, P);
            chk("R7 dstv after pause", int'(delayed_steer), 0);
        end

        // R4: one sample short
        hold(1'b1, 2'd1, 2'd1, T - 1);
        chk("R4 dstv short", int'(delayed_steer), 0);
        chk("R4 digit kept", int'(digit_out), 0);
        hold(1'b0, 2'd0, 2'd0, P);

        // R5: pair change restarts qualification
        hold(1'b1, 2'd0, 2'd0, T - 1);
        hold(1'b1, 2'd0, 2'd1, T - 1);
        chk("R5 no latch yet", int'(delayed_steer), 0);
        hold(1'b1, 2'd0, 2'd1, 1);
        chk("R5 latched dstv", int'(delayed_steer), 1);
        chk("R5 code 2", int'(digit_out), 2);
        chk("R2 early high", int'(early_steer), 1);

        // R2 / R6: short dropout, then a different pair
        hold(1'b0, 2'd0, 2'd0, 1);
        chk("R2 early drops", int'(early_steer), 0);
        hold(1'b0, 2'd0, 2'd0, P - 2);
        chk("R6 dstv bridged", int'(delayed_steer), 1);
        hold(1'b1, 2'd2, 2'd2, T + 1);
        chk("R6 dstv still", int'(delayed_steer), 1);
        chk("R6 digit kept", int'(digit_out), 2);

        // R7: pause edge
        hold(1'b0, 2'd0, 2'd0, P - 1);
        chk("R7 one short", int'(delayed_steer), 1);
        hold(1'b0, 2'd0, 2'd0, 1);
        chk("R7 pause done", int'(delayed_steer), 0);
        hold(1'b1, 2'd2, 2'd0, T);
        chk("R7 next digit", int'(digit_out), 7);
        hold(1'b0, 2'd0, 2'd0, P);

        // R10: power-down while held
        hold(1'b1, 2'd1, 2'd0, T);
        chk("R10 pre code", int'(digit_out), 4);
        power_down = 1'b1;
        hold(1'b1, 2'd1, 2'd0, 1);
        chk("R10 early low", int'(early_steer), 0);
        chk("R10 dstv low", int'(delayed_steer), 0);
        chk("R10 latch kept", int'(digit_out), 4);
        power_down = 1'b0;
        hold(1'b0, 2'd0, 2'd0, P);
        // R10: power-down aborts qualification
        hold(1'b1, 2'd1, 2'd2, T - 1);
        power_down = 1'b1;
        hold(1'b1, 2'd1, 2'd2, 1);
        power_down = 1'b0;
        hold(1'b1, 2'd1, 2'd2, T - 1);
        chk("R10 restart", int'(delayed_steer), 0);
        hold(1'b1, 2'd1, 2'd2, 1);
        chk("R10 code 6", int'(digit_out), 6);
        hold(1'b0, 2'd0, 2'd0, P);

        // R8: inhibit of column 3
        col4_inhibit = 1'b1;
        hold(1'b1, 2'd0, 2'd3, T + 2);
        chk("R8 early masked", int'(early_steer), 0);
        chk("R8 dstv masked", int'(delayed_steer), 0);
        chk("R8 digit kept", int'(digit_out), 6);
        hold(1'b1, 2'd0, 2'd2, T);
        chk("R8 other col ok", int'(digit_out), 3);
        hold(1'b0, 2'd0, 2'd0, P);
        col4_inhibit = 1'b0;

        // R9: output enable
        out_en = 1'b0;
        #1;
        chk("R9 disabled", int'(digit_out), 0);
        out_en = 1'b1;
        #1;
        chk("R9 enabled", int'(digit_out), 3);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule